// File: doc/BRIEF.md
# Low-Power Mode Controller with Wake Timer

This block sits beside a CPU core and manages its two sleep states. Software writes a small control register holding a light-sleep bit and a deep-sleep bit. Light sleep (idle) stops instruction execution but keeps the oscillator and the peripheral clocks running. Deep sleep (power-down) also gates the oscillator enable. Register and memory contents are never cleared by either mode.

The block chooses the exit path for each mode. Idle ends on any enabled interrupt. Power-down ends either on reset or on an external interrupt that is both enabled and set to level-sensitive. An interrupt exit from power-down turns the oscillator back on. A settle counter then runs for a fixed number of clocks before execution is allowed to resume, and the interrupt line does not have to stay asserted while it counts.

While the CPU sleeps, the block holds the external-bus strobes at their inactive levels. It also switches every bus-carrying pin over to its port latch. The port latch lives in this block, so the difference between a reset exit and an interrupt exit can be seen at the pins. There is no data stream through the block. Every pin is a plain control or status signal, and no valid/ready handshake applies.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, both control bits are 0 and `rd_data` reads 0. `state_o` is RUN (code 0), `exec_en` and `osc_en` are 1, and the port latch holds `PORT_RESET` (default all ones).
- R2: Control bit 0 is idle and bit 1 is power-down. A single write that sets both bits stores only power-down (`rd_data` = 0x02), and the block enters POWER-DOWN (code 2), not IDLE.
- R3: One cycle after the idle bit is stored, `state_o` is IDLE (code 1). In IDLE, `exec_en` is 0 while `osc_en` and `periph_clk_en` stay 1.
- R4: In IDLE, `periph_irq` or an enabled `ext_irq` (level or edge) returns the block to RUN on the next clock edge.
- R5: In POWER-DOWN, `exec_en`, `osc_en` and `periph_clk_en` are 0. The following do not wake the block: an external interrupt configured as edge (`ext_level`=0), a disabled external interrupt, and `periph_irq`.
- R6: An enabled level-sensitive `ext_irq` in POWER-DOWN moves the block to WAKE (code 3) with `osc_en`=1 and `exec_en`=0. The block stays in WAKE for exactly `WAKE_CYCLES` clocks even if the interrupt drops, then returns to RUN.
- R7: Whenever the state is not RUN, `ale_out` is 0 and `psen_n_out` is 1. In RUN they follow `cpu_ale` and `cpu_psen_n`.
- R8: In RUN, a pin with `bus_sel`=1 drives `bus_out` and a pin with `bus_sel`=0 drives the port latch. Outside RUN, every pin drives the port latch.
- R9: An exit from POWER-DOWN by reset restores the port latch to `PORT_RESET`. An exit by interrupt leaves the latch unchanged.
- R10: The mode bit that caused entry is cleared as the block returns to RUN, so `rd_data` reads 0 afterwards and the block stays in RUN.
- R11: Writes to reserved control bits (7..2) are ignored. Those bits read as 0, and a write of only reserved bits leaves the block in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the oscillator-clock reference for the wake count |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe (accepted in RUN) |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| periph_irq | input | 1 | An enabled peripheral interrupt is pending |
| ext_irq | input | 1 | External interrupt request |
| ext_en | input | 1 | External interrupt enable |
| ext_level | input | 1 | 1 = external interrupt is level-sensitive, 0 = edge |
| exec_en | output | 1 | CPU may execute instructions |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| state_o | output | 2 | 0 RUN, 1 IDLE, 2 POWER-DOWN, 3 WAKE |
| cpu_ale | input | 1 | Address-latch strobe from the core |
| cpu_psen_n | input | 1 | Program-store read strobe from the core, active low |
| ale_out | output | 1 | Address-latch strobe to the pins |
| psen_n_out | output | 1 | Program-store read strobe to the pins |
| port_wr | input | 1 | Port latch write strobe |
| port_wdata | input | NPINS | Port latch write value |
| bus_sel | input | NPINS | Per-pin flag: pin carries the external bus |
| bus_out | input | NPINS | External bus value from the core |
| port_q | output | NPINS | Port latch contents |
| pin_out | output | NPINS | Value driven on the pins |

## Verification
The bench builds the block with `WAKE_CYCLES` left at 9892, so the settle window is measured at its true length. The check falls on the exact last cycle of WAKE and on the first cycle of RUN after it. `NPINS` is 8, with the low nibble marked as bus pins and a bus pattern that differs from both latch values. This lets a single comparison tell a bus-driven pin from a latch-driven one, and a reset-restored latch from a retained one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2,
    ST_WAKE = 2'd3
  } lpm_state_t;

  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;
endpackage

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_allow,
  input  logic          clr,
  output logic          idle_q,
  output logic          pd_q,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (clr) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (wr_en && wr_allow) begin
      // deep sleep wins a same-write conflict
      pd_q   <= wr_data[PD_BIT];
      idle_q <= wr_data[IDLE_BIT] & ~wr_data[PD_BIT];
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[IDLE_BIT] = idle_q;
    rd_data[PD_BIT]   = pd_q;
  end

  assert_pd_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_allow && !clr && wr_data[PD_BIT]) |=> (pd_q && !idle_q));
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int CYCLES = 9892
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && (cnt == LAST);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt != LAST) |=> (!run_i || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int WAKE_CYCLES = 9892
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_q,
  input  logic       pd_q,
  input  logic       periph_irq,
  input  logic       ext_irq,
  input  logic       ext_en,
  input  logic       ext_level,
  output lpm_state_t state_o,
  output logic       clr_o
);
  lpm_state_t state, nxt;
  logic wake_done, idle_wake, pd_wake;

  assign idle_wake = periph_irq || (ext_irq && ext_en);
  assign pd_wake   = ext_irq && ext_en && ext_level;

  lpm_wake_timer #(.CYCLES(WAKE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state == ST_WAKE),
    .done_o(wake_done)
  );

  always_comb begin
    nxt   = state;
    clr_o = 1'b0;
    unique case (state)
      ST_RUN:  if (pd_q) nxt = ST_PD;
               else if (idle_q) nxt = ST_IDLE;
      ST_IDLE: if (idle_wake) begin nxt = ST_RUN; clr_o = 1'b1; end
      ST_PD:   if (pd_wake) nxt = ST_WAKE;
      ST_WAKE: if (wake_done) begin nxt = ST_RUN; clr_o = 1'b1; end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign state_o = state;

  assert_pd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && !(ext_irq && ext_en && ext_level)) |=> state == ST_PD);
  assert_wake_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && !wake_done) |=> state == ST_WAKE);
  assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_RUN));
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux #(
  parameter int          NPINS      = 8,
  parameter logic [NPINS-1:0] PORT_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_wr,
  input  logic [NPINS-1:0] port_wdata,
  input  logic [NPINS-1:0] bus_sel,
  input  logic [NPINS-1:0] bus_out,
  input  logic             sleeping,
  input  logic             cpu_ale,
  input  logic             cpu_psen_n,
  output logic [NPINS-1:0] port_q,
  output logic [NPINS-1:0] pin_out,
  output logic             ale_out,
  output logic             psen_n_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= PORT_RESET;
    else if (port_wr) port_q <= port_wdata;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_out[i] = (bus_sel[i] && !sleeping) ? bus_out[i] : port_q[i];
  end

  assign ale_out    = sleeping ? 1'b0 : cpu_ale;
  assign psen_n_out = sleeping ? 1'b1 : cpu_psen_n;

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(port_q));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int               WAKE_CYCLES = 9892,
  parameter int               NPINS       = 8,
  parameter logic [NPINS-1:0] PORT_RESET  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             periph_irq,
  input  logic             ext_irq,
  input  logic             ext_en,
  input  logic             ext_level,
  output logic             exec_en,
  output logic             osc_en,
  output logic             periph_clk_en,
  output logic [1:0]       state_o,
  input  logic             cpu_ale,
  input  logic             cpu_psen_n,
  output logic             ale_out,
  output logic             psen_n_out,
  input  logic             port_wr,
  input  logic [NPINS-1:0] port_wdata,
  input  logic [NPINS-1:0] bus_sel,
  input  logic [NPINS-1:0] bus_out,
  output logic [NPINS-1:0] port_q,
  output logic [NPINS-1:0] pin_out
);
  lpm_state_t st;
  logic idle_q, pd_q, clr, running;

  assign running = (st == ST_RUN);

  lpm_ctrl_reg #(.DW(8)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_allow(running), .clr(clr), .idle_q(idle_q), .pd_q(pd_q),
    .rd_data(rd_data)
  );

  lpm_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_q(idle_q), .pd_q(pd_q),
    .periph_irq(periph_irq), .ext_irq(ext_irq), .ext_en(ext_en),
    .ext_level(ext_level), .state_o(st), .clr_o(clr)
  );

  lpm_pin_mux #(.NPINS(NPINS), .PORT_RESET(PORT_RESET)) u_pins (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
    .bus_sel(bus_sel), .bus_out(bus_out), .sleeping(!running),
    .cpu_ale(cpu_ale), .cpu_psen_n(cpu_psen_n), .port_q(port_q),
    .pin_out(pin_out), .ale_out(ale_out), .psen_n_out(psen_n_out)
  );

  assign state_o       = st;
  assign exec_en       = running;
  assign osc_en        = (st != ST_PD);
  assign periph_clk_en = (st != ST_PD);

  assert_clr_on_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(!running) && running == 1'b0 && clr) |=> (running && !idle_q && !pd_q));
endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int W  = 9892;
  localparam int NP = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [7:0] wr_data = 0; logic [7:0] rd_data;
  logic periph_irq = 0, ext_irq = 0, ext_en = 0, ext_level = 0;
  logic exec_en, osc_en, periph_clk_en; logic [1:0] state_o;
  logic cpu_ale = 1, cpu_psen_n = 0, ale_out, psen_n_out;
  logic port_wr = 0; logic [NP-1:0] port_wdata = 0;
  logic [NP-1:0] bus_sel = 8'h0F, bus_out = 8'hA5, port_q, pin_out;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.WAKE_CYCLES(W), .NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .periph_irq(periph_irq), .ext_irq(ext_irq), .ext_en(ext_en), .ext_level(ext_level),
    .exec_en(exec_en), .osc_en(osc_en), .periph_clk_en(periph_clk_en), .state_o(state_o),
    .cpu_ale(cpu_ale), .cpu_psen_n(cpu_psen_n), .ale_out(ale_out), .psen_n_out(psen_n_out),
    .port_wr(port_wr), .port_wdata(port_wdata), .bus_sel(bus_sel), .bus_out(bus_out),
    .port_q(port_q), .pin_out(pin_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_ctrl(logic [7:0] v);
    wr_en = 1; wr_data = v; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0); chk("R1 rd", rd_data, 0);
    chk("R1 exec", exec_en, 1); chk("R1 osc", osc_en, 1);
    chk("R1 latch", port_q, 8'hFF);
    chk("R8 run pins", pin_out, 8'hF5);
    chk("R7 run ale", ale_out, 1); chk("R7 run psen", psen_n_out, 0);
  endtask

  task automatic t_reserved();
    write_ctrl(8'hFC); chk("R11 rd", rd_data, 0);
    tick(); chk("R11 state", state_o, 0); chk("R11 exec", exec_en, 1);
  endtask

  task automatic t_idle_periph();
    write_ctrl(8'h01); chk("R3 rd", rd_data, 1);
    tick(); chk("R3 state", state_o, 1); chk("R3 exec", exec_en, 0);
    chk("R3 osc", osc_en, 1); chk("R3 pclk", periph_clk_en, 1);
    chk("R7 idle ale", ale_out, 0); chk("R7 idle psen", psen_n_out, 1);
    chk("R8 idle pins", pin_out, 8'hFF);
    tick(); chk("R3 stays", state_o, 1);
    periph_irq = 1; tick(); periph_irq = 0;
    chk("R4 periph exit", state_o, 0); chk("R10 idle clr", rd_data, 0);
    tick(); chk("R10 stays run", state_o, 0);
  endtask

  task automatic t_idle_ext();
    write_ctrl(8'h01); tick(); chk("R3 state2", state_o, 1);
    ext_irq = 1; ext_en = 1; ext_level = 0; tick();
    ext_irq = 0; ext_en = 0;
    chk("R4 ext edge exit", state_o, 0);
  endtask

  task automatic t_pd_conflict_ignore();
    port_wr = 1; port_wdata = 8'h5A; tick(); port_wr = 0;
    chk("R8 run pins latch", pin_out, 8'h55);
    write_ctrl(8'h03); chk("R2 rd", rd_data, 8'h02);
    tick(); chk("R2 state pd", state_o, 2);
    chk("R5 osc", osc_en, 0); chk("R5 exec", exec_en, 0); chk("R5 pclk", periph_clk_en, 0);
    chk("R7 pd ale", ale_out, 0); chk("R8 pd pins", pin_out, 8'h5A);
    ext_irq = 1; ext_en = 1; ext_level = 0; tick(); chk("R5 edge ignored", state_o, 2);
    ext_en = 0; ext_level = 1; tick(); chk("R5 disabled ignored", state_o, 2);
    ext_irq = 0; periph_irq = 1; tick(); periph_irq = 0; chk("R5 periph ignored", state_o, 2);
  endtask

  task automatic t_pd_wake();
    ext_irq = 1; ext_en = 1; ext_level = 1; tick();
    ext_irq = 0; ext_en = 0; ext_level = 0;
    chk("R6 wake state", state_o, 3); chk("R6 osc on", osc_en, 1); chk("R6 exec off", exec_en, 0);
    repeat (W - 1) tick();
    chk("R6 last wake cycle", state_o, 3); chk("R6 exec still off", exec_en, 0);
    tick(); chk("R6 run", state_o, 0); chk("R6 exec on", exec_en, 1);
    chk("R10 pd clr", rd_data, 0); chk("R9 latch kept", port_q, 8'h5A);
  endtask

  task automatic t_pd_reset_exit();
    write_ctrl(8'h02); tick(); chk("R2 pd again", state_o, 2);
    rst_n = 0; tick(); rst_n = 1; tick();
    chk("R9 reset latch", port_q, 8'hFF); chk("R9 reset state", state_o, 0);
    chk("R9 reset exec", exec_en, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      summary();
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_reserved();
    t_idle_periph();
    t_idle_ext();
    t_pd_conflict_ignore();
    t_pd_wake();
    t_pd_reset_exit();
    done = 1;
    summary();
  end
endmodule